// File: doc/BRIEF.md
# Grouped Interrupt Sense and Summary Controller

This block collects raw interrupt lines from a group of peripherals, eight lines per peripheral, and turns them into one host interrupt. For every line, software picks edge or level sensing and the active polarity. A sense event sets a sticky latched bit. A latched bit counts as pending only while its line is enabled. The host reads a two-level status to find the source. First it reads a summary byte that holds one bit per peripheral. Then it reads that peripheral's latched or pending byte. It clears the handled bits with a write-one-to-clear register.

All access goes through a simple synchronous register bus with a 16-bit address and 8-bit data. A write takes effect on the clock edge where the write strobe is high. A read returns its data on `bus_rdata` one cycle after the read strobe. Each peripheral owns a 256-byte window. The upper address byte selects the peripheral and the lower byte selects the register.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, these all read zero: every type, polarity-high, polarity-low, enable and latched register, every summary byte, `bus_rdata` and `host_irq`.
- R2: Peripheral p sits at address ((PBASE+p) << 8) | offset, with PBASE = 0x10. The type (0x11), polarity-high (0x12) and polarity-low (0x13) registers are read/write and read back the last value written. A write to one peripheral does not change the registers of any other peripheral.
- R3: The real-time register (0x10) returns each raw line after a two-flop synchroniser. Bit n of every per-peripheral register is line n, with bit 0 as the LSB.
- R4: A type bit of 1 selects edge sensing. On an edge line, polarity-high alone latches on a rising edge, polarity-low alone latches on a falling edge, and both bits set latch on either edge.
- R5: A type bit of 0 selects level sensing. Polarity-high latches while the line is high and polarity-low latches while it is low. The bit is set again on every cycle the level stays active.
- R6: A 1 written to latched-clear (0x14) clears that latched bit and 0 bits leave it alone. When a sense event and a clear hit the same bit in the same cycle, the bit ends up set. Without a clear, a latched bit never falls.
- R7: A 1 written to enable-set (0x15) enables that line and a 1 written to enable-clear (0x16) disables it. 0 bits change nothing, and 0xFF on enable-clear disables the whole peripheral. Reading 0x15 returns the enable mask. Enables change only on writes.
- R8: Latched status (0x18) records events whether or not the line is enabled. Pending status (0x19) equals latched AND enabled.
- R9: Summary byte i, at 0x0550+i, has bit k set when peripheral 8i+k has any pending bit. `host_irq` is the OR of all pending bits, registered one cycle later.
- R10: Writes to the real-time, latched, pending and summary addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (16) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Read data, valid the cycle after `bus_rd` |
| irq_in | input | N_PERIPH*W (64) | Raw interrupt lines; peripheral p uses bits p*8+7..p*8 |
| host_irq | output | 1 | Combined registered host interrupt |

## Verification
The bench checks edge and level sensing with a single line per polarity choice. A design that swapped the rising and falling terms, or treated both-edges as rising-only, would latch the wrong bits after each transition. For a level line held active, the bench writes a clear and expects the bit to stay set. A design that let the clear win would drop the bit. The bench also checks that enable-set and enable-clear leave the 0 bits alone, that pending stays masked while latched is set, and that the summary and host interrupt follow pending from two peripherals at once. It writes to the status-only addresses and expects no change, which would catch a decoder that aliased them onto writable state.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  // Register offsets in the low address byte; software decodes these.
  localparam logic [7:0] OFS_RT    = 8'h10;
  localparam logic [7:0] OFS_TYPE  = 8'h11;
  localparam logic [7:0] OFS_POLH  = 8'h12;
  localparam logic [7:0] OFS_POLL  = 8'h13;
  localparam logic [7:0] OFS_LCLR  = 8'h14;
  localparam logic [7:0] OFS_ENSET = 8'h15;
  localparam logic [7:0] OFS_ENCLR = 8'h16;
  localparam logic [7:0] OFS_LAT   = 8'h18;
  localparam logic [7:0] OFS_PEND  = 8'h19;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irqc_periph.sv
`timescale 1ns/1ps
module irqc_periph
  import irqc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic         sel,
  input  logic         wr,
  input  logic [7:0]   ofs,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] typ,
  output logic [W-1:0] en,
  output logic [W-1:0] lat,
  output logic [W-1:0] clr_mask,
  output logic [W-1:0] pend,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] s_now, s_prev, polh, poll;
  logic [W-1:0] rise, fall, ev;
  logic         hit;

  irqc_sync #(.W(W)) u_sync (.clk(clk), .rst(rst), .d(raw), .q(s_now));

  assign hit      = sel & wr;
  assign clr_mask = (hit && ofs == OFS_LCLR) ? wdata : '0;
  assign rise     = s_now & ~s_prev;
  assign fall     = ~s_now & s_prev;
  assign ev       = (typ & ((polh & rise) | (poll & fall)))
                  | (~typ & ((polh & s_now) | (poll & ~s_now)));
  assign pend     = lat & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_prev <= '0;
      typ    <= '0;
      polh   <= '0;
      poll   <= '0;
      en     <= '0;
      lat    <= '0;
    end else begin
      s_prev <= s_now;
      lat    <= (lat & ~clr_mask) | ev;
      if (hit) begin
        case (ofs)
          OFS_TYPE:  typ  <= wdata;
          OFS_POLH:  polh <= wdata;
          OFS_POLL:  poll <= wdata;
          OFS_ENSET: en   <= en | wdata;
          OFS_ENCLR: en   <= en & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ofs)
      OFS_RT:    rd_val = s_now;
      OFS_TYPE:  rd_val = typ;
      OFS_POLH:  rd_val = polh;
      OFS_POLL:  rd_val = poll;
      OFS_ENSET: rd_val = en;
      OFS_LAT:   rd_val = lat;
      OFS_PEND:  rd_val = pend;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top #(
  parameter int N_PERIPH = 8,
  parameter int W        = 8,
  parameter int AW       = 16,
  parameter int PBASE    = 'h10,
  parameter int SUM_ADDR = 'h0550
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [W-1:0]          bus_wdata,
  output logic [W-1:0]          bus_rdata,
  input  logic [N_PERIPH*W-1:0] irq_in,
  output logic                  host_irq
);
  localparam int NSUM = (N_PERIPH + W - 1) / W;

  logic [N_PERIPH-1:0]   sel, pend_any;
  logic [N_PERIPH*W-1:0] typ_all, en_all, lat_all, clr_all;
  logic [W-1:0]          rd_vals [N_PERIPH];
  logic [NSUM*W-1:0]     sum_flat;
  logic [W-1:0]          rd_next;

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
    logic [W-1:0] pend_p;
    assign sel[p] = (bus_addr[AW-1:8] == (AW-8)'(PBASE + p));
    irqc_periph #(.W(W)) u_per (
      .clk(clk), .rst(rst), .raw(irq_in[p*W +: W]),
      .sel(sel[p]), .wr(bus_wr), .ofs(bus_addr[7:0]), .wdata(bus_wdata),
      .typ(typ_all[p*W +: W]), .en(en_all[p*W +: W]),
      .lat(lat_all[p*W +: W]), .clr_mask(clr_all[p*W +: W]),
      .pend(pend_p), .rd_val(rd_vals[p])
    );
    assign pend_any[p] = |pend_p;
  end

  always_comb begin
    sum_flat = '0;
    sum_flat[N_PERIPH-1:0] = pend_any;
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < N_PERIPH; p++)
      if (sel[p]) rd_next = rd_vals[p];
    for (int i = 0; i < NSUM; i++)
      if (bus_addr == AW'(SUM_ADDR + i)) rd_next = sum_flat[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      host_irq  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      host_irq <= |pend_any;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
  parameter int N_PERIPH = 8,
  parameter int W        = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic                  host_irq,
  input logic [N_PERIPH*W-1:0] typ_all,
  input logic [N_PERIPH*W-1:0] en_all,
  input logic [N_PERIPH*W-1:0] lat_all,
  input logic [N_PERIPH*W-1:0] clr_all
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (lat_all == '0 && en_all == '0 && typ_all == '0 && !host_irq));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(typ_all));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(lat_all) & ~$past(clr_all)) & ~lat_all) == '0));

  p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(en_all));

  p_host_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (host_irq == $past(|(lat_all & en_all))));
endmodule

bind irqc_top irqc_checker #(.N_PERIPH(N_PERIPH), .W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .host_irq(host_irq),
  .typ_all(typ_all), .en_all(en_all), .lat_all(lat_all), .clr_all(clr_all)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [63:0] irq_in;
  logic        host_irq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .host_irq(host_irq)
  );

  function automatic logic [15:0] ra(int p, logic [7:0] ofs);
    return {8'(8'h10 + p), ofs};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic drive(int p, logic [7:0] v);
    @(negedge clk);
    irq_in[p*8 +: 8] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 bus_rdata", bus_rdata, 8'h00);
    chk("R1 host_irq", {7'b0, host_irq}, 8'h00);
    rd_chk("R1 type p0", ra(0, 8'h11), 8'h00);
    rd_chk("R1 enable p3", ra(3, 8'h15), 8'h00);
    rd_chk("R1 latched p7", ra(7, 8'h18), 8'h00);
    rd_chk("R1 summary", 16'h0550, 8'h00);
  endtask

  task automatic t_cfg;
    wr(ra(2, 8'h11), 8'hA5);
    wr(ra(2, 8'h12), 8'h3C);
    wr(ra(5, 8'h13), 8'h81);
    rd_chk("R2 type p2", ra(2, 8'h11), 8'hA5);
    rd_chk("R2 polh p2", ra(2, 8'h12), 8'h3C);
    rd_chk("R2 poll p5", ra(5, 8'h13), 8'h81);
    rd_chk("R2 type p3 untouched", ra(3, 8'h11), 8'h00);
  endtask

  task automatic t_rt;
    drive(1, 8'h5A);
    rd_chk("R3 realtime p1", ra(1, 8'h10), 8'h5A);
    drive(1, 8'h00);
    rd_chk("R3 realtime p1 low", ra(1, 8'h10), 8'h00);
  endtask

  task automatic t_edge;
    wr(ra(0, 8'h11), 8'h07);
    wr(ra(0, 8'h12), 8'h03);
    wr(ra(0, 8'h13), 8'h06);
    drive(0, 8'h07);
    rd_chk("R4 rising latches lines 0,1", ra(0, 8'h18), 8'h03);
    wr(ra(0, 8'h14), 8'hFF);
    rd_chk("R4 cleared", ra(0, 8'h18), 8'h00);
    drive(0, 8'h00);
    rd_chk("R4 falling latches lines 1,2", ra(0, 8'h18), 8'h06);
    wr(ra(0, 8'h14), 8'hFF);
    repeat (3) @(negedge clk);
    rd_chk("R4 no event when steady", ra(0, 8'h18), 8'h00);
  endtask

  task automatic t_level;
    wr(ra(4, 8'h12), 8'h01);
    wr(ra(4, 8'h13), 8'h02);
    repeat (3) @(negedge clk);
    rd_chk("R5 active-low latched", ra(4, 8'h18), 8'h02);
    drive(4, 8'h01);
    rd_chk("R5 active-high latched", ra(4, 8'h18), 8'h03);
    wr(ra(4, 8'h14), 8'h01);
    rd_chk("R6 set wins over clear", ra(4, 8'h18), 8'h03);
    drive(4, 8'h00);
    wr(ra(4, 8'h14), 8'h01);
    rd_chk("R6 clear one bit", ra(4, 8'h18), 8'h02);
    wr(ra(4, 8'h14), 8'h00);
    rd_chk("R6 zero bits no effect", ra(4, 8'h18), 8'h02);
    drive(4, 8'h02);
    wr(ra(4, 8'h14), 8'h02);
    rd_chk("R6 inactive level clears", ra(4, 8'h18), 8'h00);
  endtask

  task automatic t_enable;
    wr(ra(6, 8'h15), 8'h0F);
    rd_chk("R7 enable-set", ra(6, 8'h15), 8'h0F);
    wr(ra(6, 8'h16), 8'h03);
    rd_chk("R7 enable-clear", ra(6, 8'h15), 8'h0C);
    wr(ra(6, 8'h15), 8'h00);
    rd_chk("R7 zero set no change", ra(6, 8'h15), 8'h0C);
    wr(ra(6, 8'h16), 8'hFF);
    rd_chk("R7 clear all", ra(6, 8'h15), 8'h00);
    wr(ra(6, 8'h12), 8'h08);
    drive(6, 8'h08);
    rd_chk("R8 latched while disabled", ra(6, 8'h18), 8'h08);
    rd_chk("R8 pending masked", ra(6, 8'h19), 8'h00);
    chk("R9 host_irq idle", {7'b0, host_irq}, 8'h00);
    wr(ra(6, 8'h15), 8'h08);
    rd_chk("R8 pending enabled", ra(6, 8'h19), 8'h08);
    rd_chk("R9 summary p6", 16'h0550, 8'h40);
    chk("R9 host_irq set", {7'b0, host_irq}, 8'h01);
    wr(ra(5, 8'h15), 8'h80);
    rd_chk("R9 summary p5,p6", 16'h0550, 8'h60);
  endtask

  task automatic t_ro;
    wr(ra(5, 8'h18), 8'h00);
    wr(ra(5, 8'h19), 8'h00);
    wr(ra(5, 8'h10), 8'hFF);
    rd_chk("R10 latched ignores writes", ra(5, 8'h18), 8'h81);
    rd_chk("R10 pending ignores writes", ra(5, 8'h19), 8'h80);
    wr(16'h0550, 8'h00);
    rd_chk("R10 summary ignores writes", 16'h0550, 8'h60);
    wr(ra(5, 8'h16), 8'hFF);
    wr(ra(6, 8'h16), 8'hFF);
    repeat (2) @(negedge clk);
    chk("R9 host_irq cleared", {7'b0, host_irq}, 8'h00);
    rd_chk("R9 summary empty", 16'h0550, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; irq_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_rt;
    t_edge;
    t_level;
    t_enable;
    t_ro;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule